// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block sits behind the register port of an interrupt controller and handles writes to the control word that lets one CPU raise a software interrupt on other CPUs. A full-word write carries an interrupt number, an explicit list of target CPUs and a two-bit filter mode. The block turns that word into a set of target CPUs. The filter mode can replace the written list with "every online CPU except the sender" or with "the sender alone". For each target the block then sends one set-pending pulse downstream.

Each pulse goes out with the interrupt number and a one-hot tag for the requesting CPU. A source-tracking bank further down can then record, for every CPU and every interrupt number, which CPUs have raised it. The count of online CPUs limits every mode, so a CPU that is not online is never targeted. The register cannot be read back: its read value is always zero.

Top module: `sgi_dispatch`

## Requirements
- R1: On a pulse, `set_sgi` equals bits [3:0] of the accepted write word, so 16 interrupt numbers can be raised.
- R2: When mode bits [25:24] = 0, the targets are the list in bits [23:16], where bit 16+i selects CPU i.
- R3: When mode bits [25:24] = 1, the targets are every online CPU except `req_cpu`, whatever the list bits hold.
- R4: When mode bits [25:24] = 2, the only target is `req_cpu`, and only if that CPU is online.
- R5: When mode bits [25:24] = 3, the write raises no pulse.
- R6: On a pulse, `set_src` is one-hot with bit `req_cpu` set, where `req_cpu` is taken from the accepting cycle.
- R7: CPU i is targeted only if i < `online_cnt`. An `online_cnt` above the CPU count is treated as the CPU count, and a count of 0 targets nobody.
- R8: `set_valid` is high for exactly the one cycle after the clock edge that accepts the write. Back-to-back writes produce back-to-back pulses.
- R9: A write is accepted only when `wr_en` is high and all four bits of `wr_be` are high. Otherwise no pulse is raised.
- R10: `rd_data` is always zero.
- R11: After reset, `set_valid`, `set_sgi` and `set_src` are all zero. Between pulses they also return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write word: number [3:0], list [23:16], mode [25:24] |
| req_cpu | input | 3 | Index of the requesting CPU |
| online_cnt | input | 4 | Number of online CPUs (0 to 8) |
| rd_data | output | 32 | Read value of the register, always zero |
| set_valid | output | 8 | One set-pending pulse per target CPU |
| set_sgi | output | 4 | Interrupt number that goes with the pulses |
| set_src | output | 8 | One-hot tag of the requesting CPU |

## Verification
Explicit lists are written with sparse, full and top-bit-only patterns under several online counts. These patterns separate "pass the list" from "pass the list clipped to the online CPUs". The broadcast mode is tried with different senders, including the only online CPU and a count above eight, which shows whether the sender's bit is cleared and where the count saturates. Self mode with an offline sender, reserved mode with a full list, partial byte enables and stray bits outside the fields each test a path that has to stay silent or unaffected. Back-to-back writes check that each pulse lasts one cycle and follows its own write.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } flt_mode_e;

  localparam int SGI_ID_LSB = 0;
  localparam int TGT_LSB    = 16;
  localparam int MODE_LSB   = 24;
endpackage

// File: rtl/sgi_field_decode.sv
module sgi_field_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int DATA_W   = 32,
  parameter int SGI_W    = 4,
  localparam int BE_W    = DATA_W / 8
) (
  input  logic                wr_en,
  input  logic [BE_W-1:0]     wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                accept,
  output logic [SGI_W-1:0]    sgi_id,
  output logic [NUM_CPUS-1:0] tgt_list,
  output flt_mode_e           mode
);
  assign accept   = wr_en && (&wr_be);
  assign sgi_id   = wr_data[SGI_ID_LSB +: SGI_W];
  assign tgt_list = wr_data[TGT_LSB +: NUM_CPUS];
  assign mode     = flt_mode_e'(wr_data[MODE_LSB +: 2]);

  logic unused_fields;
  assign unused_fields = ^wr_data;
endmodule

// File: rtl/sgi_target_calc.sv
module sgi_target_calc
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  localparam int IDX_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int CNT_W   = $clog2(NUM_CPUS + 1)
) (
  input  flt_mode_e           mode,
  input  logic [NUM_CPUS-1:0] tgt_list,
  input  logic [IDX_W-1:0]    req_cpu,
  input  logic [CNT_W-1:0]    online_cnt,
  output logic [NUM_CPUS-1:0] req_oh,
  output logic [NUM_CPUS-1:0] online_mask,
  output logic [NUM_CPUS-1:0] targets
);
  function automatic logic [NUM_CPUS-1:0] mask_below(input logic [CNT_W-1:0] cnt);
    logic [NUM_CPUS-1:0] m;
    for (int i = 0; i < NUM_CPUS; i++) m[i] = (i < int'(cnt));
    return m;
  endfunction

  function automatic logic [NUM_CPUS-1:0] one_hot(input logic [IDX_W-1:0] idx);
    logic [NUM_CPUS-1:0] m;
    for (int i = 0; i < NUM_CPUS; i++) m[i] = (int'(idx) == i);
    return m;
  endfunction

  assign req_oh      = one_hot(req_cpu);
  assign online_mask = mask_below(online_cnt);

  always_comb begin
    unique case (mode)
      FLT_LIST:   targets = tgt_list & online_mask;
      FLT_OTHERS: targets = online_mask & ~req_oh;
      FLT_SELF:   targets = req_oh & online_mask;
      default:    targets = '0;
    endcase
  end
endmodule

// File: rtl/sgi_pulse_reg.sv
module sgi_pulse_reg #(
  parameter int NUM_CPUS = 8,
  parameter int SGI_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [NUM_CPUS-1:0] targets,
  input  logic [SGI_W-1:0]    sgi_id,
  input  logic [NUM_CPUS-1:0] req_oh,
  output logic [NUM_CPUS-1:0] set_valid,
  output logic [SGI_W-1:0]    set_sgi,
  output logic [NUM_CPUS-1:0] set_src
);
  logic fire;
  assign fire = load && (|targets);

  always_ff @(posedge clk) begin
    if (!rst_n || !fire) begin
      set_valid <= '0;
      set_sgi   <= '0;
      set_src   <= '0;
    end else begin
      set_valid <= targets;
      set_sgi   <= sgi_id;
      set_src   <= req_oh;
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int DATA_W   = 32,
  parameter int SGI_W    = 4,
  localparam int BE_W    = DATA_W / 8,
  localparam int IDX_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int CNT_W   = $clog2(NUM_CPUS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [BE_W-1:0]     wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    req_cpu,
  input  logic [CNT_W-1:0]    online_cnt,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_CPUS-1:0] set_valid,
  output logic [SGI_W-1:0]    set_sgi,
  output logic [NUM_CPUS-1:0] set_src
);
  logic                wr_accept;
  logic [SGI_W-1:0]    sgi_id;
  logic [NUM_CPUS-1:0] tgt_list;
  flt_mode_e           mode;
  logic [NUM_CPUS-1:0] req_oh;
  logic [NUM_CPUS-1:0] online_mask;
  logic [NUM_CPUS-1:0] targets;

  assign rd_data = '0;

  sgi_field_decode #(.NUM_CPUS(NUM_CPUS), .DATA_W(DATA_W), .SGI_W(SGI_W)) u_fields (
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .accept   (wr_accept),
    .sgi_id   (sgi_id),
    .tgt_list (tgt_list),
    .mode     (mode)
  );

  sgi_target_calc #(.NUM_CPUS(NUM_CPUS)) u_calc (
    .mode        (mode),
    .tgt_list    (tgt_list),
    .req_cpu     (req_cpu),
    .online_cnt  (online_cnt),
    .req_oh      (req_oh),
    .online_mask (online_mask),
    .targets     (targets)
  );

  sgi_pulse_reg #(.NUM_CPUS(NUM_CPUS), .SGI_W(SGI_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_accept),
    .targets   (targets),
    .sgi_id    (sgi_id),
    .req_oh    (req_oh),
    .set_valid (set_valid),
    .set_sgi   (set_sgi),
    .set_src   (set_src)
  );
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NUM_CPUS = 8,
  parameter int DATA_W   = 32,
  parameter int SGI_W    = 4,
  localparam int IDX_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int CNT_W   = $clog2(NUM_CPUS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_accept,
  input logic [DATA_W-1:0]   wr_data,
  input logic [IDX_W-1:0]    req_cpu,
  input logic [CNT_W-1:0]    online_cnt,
  input logic [NUM_CPUS-1:0] set_valid,
  input logic [SGI_W-1:0]    set_sgi,
  input logic [NUM_CPUS-1:0] set_src
);
  logic [1:0]          c_mode;
  logic [NUM_CPUS:0]   c_wide;
  logic [NUM_CPUS-1:0] c_onl;
  logic [NUM_CPUS-1:0] c_req;
  int                  c_lim;

  assign c_mode = wr_data[25:24];
  assign c_lim  = (int'(online_cnt) > NUM_CPUS) ? NUM_CPUS : int'(online_cnt);
  assign c_wide = ((NUM_CPUS+1)'(1) << c_lim) - (NUM_CPUS+1)'(1);
  assign c_onl  = c_wide[NUM_CPUS-1:0];
  assign c_req  = NUM_CPUS'(1) << req_cpu;

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> set_valid == '0);

  p_rsvd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && c_mode == 2'd3) |=> set_valid == '0);

  p_skip_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && c_mode == 2'd1) |=> (set_valid & $past(c_req)) == '0);

  p_self_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && c_mode == 2'd2) |=> set_valid == ($past(c_req) & $past(c_onl)));

  p_online_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (set_valid & ~$past(c_onl)) == '0);

  p_src_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_valid) |-> ($countones(set_src) == 1 && set_src == $past(c_req)));

  p_sgi_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_valid) |-> set_sgi == $past(wr_data[SGI_W-1:0]));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(
  .NUM_CPUS (NUM_CPUS),
  .DATA_W   (DATA_W),
  .SGI_W    (SGI_W)
) u_chk (.*);

// File: tb/sim_sgi_dispatch.sv
`timescale 1ns/1ps
module sim_sgi_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = '0;
  logic [2:0]  req_cpu = '0;
  logic [3:0]  online_cnt = 4'd8;
  logic [31:0] rd_data;
  logic [7:0]  set_valid;
  logic [3:0]  set_sgi;
  logic [7:0]  set_src;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sgi_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .req_cpu(req_cpu), .online_cnt(online_cnt), .rd_data(rd_data),
    .set_valid(set_valid), .set_sgi(set_sgi), .set_src(set_src)
  );

  // {data, req, cnt, expected targets}
  localparam logic [46:0] VEC [11] = '{
    {32'h00A5_0003, 3'd0, 4'd8,  8'hA5},  // R2 sparse list
    {32'h00FF_000F, 3'd2, 4'd4,  8'h0F},  // R2 R7 clipped list
    {32'h0100_0007, 3'd1, 4'd8,  8'hFD},  // R3 all but sender
    {32'h0100_0000, 3'd3, 4'd5,  8'h17},  // R3 partial online
    {32'h02F0_0009, 3'd6, 4'd8,  8'h40},  // R4 self
    {32'h0200_0002, 3'd5, 4'd4,  8'h00},  // R4 offline sender
    {32'h03FF_0001, 3'd0, 4'd8,  8'h00},  // R5 reserved
    {32'h0080_0004, 3'd0, 4'd7,  8'h00},  // R7 top bit offline
    {32'h0100_0005, 3'd0, 4'd1,  8'h00},  // R3 sole online cpu
    {32'hFC03_00F6, 3'd0, 4'd8,  8'h03},  // R1 stray bits
    {32'h0100_000B, 3'd7, 4'd12, 8'h7F}   // R7 count saturates
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] d, input logic [3:0] be, input logic en,
                       input logic [2:0] rq, input logic [3:0] cnt);
    @(negedge clk);
    wr_en = en; wr_be = be; wr_data = d; req_cpu = rq; online_cnt = cnt;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 valid after reset", 32'(set_valid), 0);
    chk("R11 sgi after reset", 32'(set_sgi), 0);
    chk("R11 src after reset", 32'(set_src), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 11; k++) begin
      logic [31:0] d;
      logic [2:0]  rq;
      logic [3:0]  cn;
      logic [7:0]  ex;
      {d, rq, cn, ex} = VEC[k];
      drive(d, 4'hF, 1'b1, rq, cn);
      chk($sformatf("R2/R3/R4/R5/R7 targets vec %0d", k), 32'(set_valid), 32'(ex));
      if (ex != 0) begin
        chk($sformatf("R1 sgi vec %0d", k), 32'(set_sgi), 32'(d[3:0]));
        chk($sformatf("R6 src vec %0d", k), 32'(set_src), 32'(8'(1) << rq));
      end else begin
        chk($sformatf("R11 idle src vec %0d", k), 32'(set_src), 0);
      end
      chk("R10 read zero", rd_data, 0);
      @(negedge clk);
      chk($sformatf("R8 single cycle vec %0d", k), 32'(set_valid), 0);
    end

    // R9: partial byte enables
    drive(32'h00FF_0002, 4'b0111, 1'b1, 3'd0, 4'd8);
    chk("R9 partial be", 32'(set_valid), 0);
    drive(32'h00FF_0002, 4'b1110, 1'b1, 3'd0, 4'd8);
    chk("R9 partial be high", 32'(set_valid), 0);
    // R9: enables without strobe
    drive(32'h00FF_0002, 4'hF, 1'b0, 3'd0, 4'd8);
    chk("R9 no strobe", 32'(set_valid), 0);

    // R7: zero online count
    drive(32'h00FF_0002, 4'hF, 1'b1, 3'd0, 4'd0);
    chk("R7 zero online", 32'(set_valid), 0);

    // R8: back-to-back writes
    @(negedge clk);
    wr_en = 1'b1; wr_be = 4'hF; wr_data = 32'h0011_0008; req_cpu = 3'd2; online_cnt = 4'd8;
    @(negedge clk);
    chk("R8 first of pair", 32'(set_valid), 32'h11);
    chk("R1 first sgi", 32'(set_sgi), 8);
    wr_data = 32'h0200_000C; req_cpu = 3'd3;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0;
    chk("R8 second of pair", 32'(set_valid), 32'h08);
    chk("R6 second src", 32'(set_src), 32'h08);
    chk("R1 second sgi", 32'(set_sgi), 12);
    @(negedge clk);
    chk("R8 pair ends", 32'(set_valid), 0);

    // R11: reset while a pulse would be issued
    @(negedge clk);
    wr_en = 1'b1; wr_be = 4'hF; wr_data = 32'h00FF_0001; rst_n = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0;
    chk("R11 reset wins", 32'(set_valid), 0);
    rst_n = 1'b1;
    chk("R10 read zero end", rd_data, 0);

    finish_run();
  end
endmodule